// File: doc/BRIEF.md
# Start-of-Frame Marker Generator

This block keeps a local 1 ms frame tick for a full-speed USB device controller. It runs from the 12 MHz bit clock. When the host's start-of-frame packet for a frame is corrupted or missing, the block supplies a synthetic set pulse for the SOF interrupt flag, so the frame tick carries on. Each valid SOF strobe from the packet decoder is passed to the flag set output. Each valid SOF also re-aligns the local frame counter, so the block follows the host's timing whenever real packets arrive.

Software turns the function on with an enable bit. The block does not make a synthetic tick until it has seen a valid SOF since the enable was raised. When suspend is detected, the block stops making ticks and stays stopped until the enable goes low and high again. After that it waits for a fresh valid SOF.

A four-state machine controls the block:

- `MK_OFF`: disabled. `MK_OFF -> MK_WAIT` when the enable is high.
- `MK_WAIT`: armed and waiting for a first valid SOF. `MK_WAIT -> MK_RUN` on a valid SOF. `MK_WAIT -> MK_HALT` on suspend. `MK_WAIT -> MK_OFF` when the enable drops.
- `MK_RUN`: tracking frames and filling in missing ticks. `MK_RUN -> MK_HALT` on suspend. `MK_RUN -> MK_OFF` when the enable drops.
- `MK_HALT`: stopped after suspend. `MK_HALT -> MK_OFF` only when the enable drops.

If several conditions hold at once, a low enable takes priority over suspend, and suspend takes priority over a valid SOF.

The frame period is `FRAME_CYCLES` (default 12000). The tolerance window for late packets is `WIN_CYCLES` (default 60).

Top module: `sof_marker_gen`

## Requirements
- R1: A valid SOF strobe sampled at a clock edge drives `sof_flag_set_o` high for the following cycle. This holds in every state and whatever the enable and suspend inputs are.
- R2: After reset, the machine is in `MK_OFF`, and both `sof_flag_set_o` and `mark_active_o` are 0.
- R3: While the enable is high but no valid SOF has been seen since it rose (`MK_WAIT`), no synthetic pulse is produced and `mark_active_o` stays 0.
- R4: A valid SOF sampled in `MK_WAIT` moves the machine to `MK_RUN`, and `mark_active_o` reads 1 from the next cycle.
- R5: In `MK_RUN`, if no further valid SOF arrives, a synthetic pulse appears FRAME_CYCLES+WIN_CYCLES edges after the edge that registered the last real pulse.
- R6: After a synthetic pulse, and with no real SOF, later synthetic pulses follow at intervals of exactly FRAME_CYCLES edges.
- R7: A valid SOF arriving up to and including the edge where the synthetic pulse would fall suppresses that synthetic pulse. The next deadline is then measured from the real SOF, so a frame never carries both pulses.
- R8: A valid SOF arriving after a synthetic pulse still passes through. It re-anchors the counter, and the next synthetic pulse comes FRAME_CYCLES+WIN_CYCLES edges after it.
- R9: When the enable is sampled low, the machine goes to `MK_OFF` and no synthetic pulse is produced at that edge or afterwards.
- R10: Suspend sampled high moves the machine to `MK_HALT`. `mark_active_o` then reads 0 and no synthetic pulse is produced. The machine stays halted while the enable remains high. After the enable goes low and high again, a new valid SOF is needed before ticks resume.
- R11: A synthetic pulse is never closer than FRAME_CYCLES edges to the previous pulse of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_ok_i | input | 1 | One-cycle strobe from the packet decoder: a start-of-frame packet with good CRC was received |
| mark_en_i | input | 1 | Marker function enable control bit |
| suspend_i | input | 1 | Bus suspend detected |
| sof_flag_set_o | output | 1 | One-cycle set pulse for the SOF interrupt flag (real or synthetic) |
| mark_active_o | output | 1 | High while the machine is in `MK_RUN` |

## Verification
The bench uses a short frame and a narrow window. It sweeps the arrival of the second real SOF across every edge from a few cycles before the tolerance window to a few cycles past it. This separates four outcomes: an early re-anchor, an in-window arrival that suppresses the fill-in, an arrival on the exact deadline edge, and a late packet that arrives after a synthetic pulse. Separate patterns with no SOF at all, an enable dropped exactly on a deadline edge, and a suspend held while the enable stays high show apart three cases: the arming rule, the one-clock stop on disable, and the need for a fresh SOF after re-enable.

// File: rtl/sof_marker_pkg.sv
package sof_marker_pkg;

    typedef enum logic [1:0] {
        MK_OFF  = 2'd0,
        MK_WAIT = 2'd1,
        MK_RUN  = 2'd2,
        MK_HALT = 2'd3
    } mk_state_e;

endpackage

// File: rtl/sof_frame_ctr.sv
module sof_frame_ctr #(
    parameter int FRAME_CYCLES = 12000,
    parameter int WIN_CYCLES   = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload_i,
    input  logic rebase_i,
    input  logic count_i,
    output logic at_limit_o
);
    localparam int CW = $clog2(FRAME_CYCLES + WIN_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FRAME_CYCLES + WIN_CYCLES - 1);
    localparam logic [CW-1:0] BASE  = CW'(WIN_CYCLES);

    logic [CW-1:0] cnt_q;

    // Counts edges since the last anchor. A real SOF anchors at zero.
    // A synthetic tick anchors at the nominal slot, which lies WIN_CYCLES
    // edges in the past.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload_i) begin
            cnt_q <= '0;
        end else if (rebase_i) begin
            cnt_q <= BASE;
        end else if (count_i && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit_o = (cnt_q == LIMIT);

endmodule

// File: rtl/sof_marker_fsm.sv
module sof_marker_fsm
    import sof_marker_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      susp_i,
    input  logic      sof_i,
    input  logic      limit_i,
    output mk_state_e state_o,
    output logic      synth_o,
    output logic      reload_o,
    output logic      rebase_o,
    output logic      count_o
);
    mk_state_e state_q;
    mk_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MK_OFF: begin
                if (en_i) state_d = MK_WAIT;
            end
            MK_WAIT: begin
                if (!en_i)       state_d = MK_OFF;
                else if (susp_i) state_d = MK_HALT;
                else if (sof_i)  state_d = MK_RUN;
            end
            MK_RUN: begin
                if (!en_i)       state_d = MK_OFF;
                else if (susp_i) state_d = MK_HALT;
            end
            MK_HALT: begin
                if (!en_i) state_d = MK_OFF;
            end
            default: state_d = MK_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MK_OFF;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        synth_o  = 1'b0;
        count_o  = 1'b0;
        reload_o = sof_i;
        unique case (state_q)
            MK_RUN: begin
                count_o = 1'b1;
                synth_o = en_i && !susp_i && !sof_i && limit_i;
            end
            MK_OFF, MK_WAIT, MK_HALT: begin
                count_o = 1'b0;
            end
            default: count_o = 1'b0;
        endcase
        rebase_o = synth_o;
    end

    assign state_o = state_q;

endmodule

// File: rtl/sof_marker_gen.sv
module sof_marker_gen
    import sof_marker_pkg::*;
#(
    parameter int FRAME_CYCLES = 12000,
    parameter int WIN_CYCLES   = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_ok_i,
    input  logic mark_en_i,
    input  logic suspend_i,
    output logic sof_flag_set_o,
    output logic mark_active_o
);
    mk_state_e state;
    logic      at_limit;
    logic      synth;
    logic      reload;
    logic      rebase;
    logic      count;
    logic      flag_q;

    sof_marker_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (mark_en_i),
        .susp_i   (suspend_i),
        .sof_i    (sof_ok_i),
        .limit_i  (at_limit),
        .state_o  (state),
        .synth_o  (synth),
        .reload_o (reload),
        .rebase_o (rebase),
        .count_o  (count)
    );

    sof_frame_ctr #(
        .FRAME_CYCLES (FRAME_CYCLES),
        .WIN_CYCLES   (WIN_CYCLES)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_i   (reload),
        .rebase_i   (rebase),
        .count_i    (count),
        .at_limit_o (at_limit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= sof_ok_i | synth;
    end

    assign sof_flag_set_o = flag_q;
    assign mark_active_o  = (state == MK_RUN);

endmodule

// File: rtl/sof_marker_chk.sv
module sof_marker_chk #(
    parameter int FRAME_CYCLES = 12000,
    parameter int WIN_CYCLES   = 60
) (
    input logic clk,
    input logic rst_n,
    input logic sof_ok_i,
    input logic mark_en_i,
    input logic suspend_i,
    input logic sof_flag_set_o,
    input logic mark_active_o
);
    localparam int GMAX = FRAME_CYCLES + WIN_CYCLES + 1;
    localparam int GW   = $clog2(GMAX + 1);
    localparam logic [GW-1:0] GSAT  = GW'(GMAX);
    localparam logic [GW-1:0] GMINP = GW'(FRAME_CYCLES);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= GSAT;
        else if (sof_flag_set_o) gap_q <= GW'(1);
        else if (gap_q != GSAT)  gap_q <= gap_q + 1'b1;
    end

    // R1
    real_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_ok_i |=> sof_flag_set_o);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mark_active_o && !sof_ok_i) |=> !sof_flag_set_o);

    // R9
    disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mark_en_i && !sof_ok_i) |=> !sof_flag_set_o);

    // R10
    suspend_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |=> !mark_active_o);

    // R11
    synth_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_flag_set_o && !$past(sof_ok_i)) |-> (gap_q >= GMINP));

endmodule

bind sof_marker_gen sof_marker_chk #(
    .FRAME_CYCLES (FRAME_CYCLES),
    .WIN_CYCLES   (WIN_CYCLES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sof_ok_i       (sof_ok_i),
    .mark_en_i      (mark_en_i),
    .suspend_i      (suspend_i),
    .sof_flag_set_o (sof_flag_set_o),
    .mark_active_o  (mark_active_o)
);

// File: tb/tb_sof_marker_gen.sv
`timescale 1ns/1ps
module tb_sof_marker_gen;
    localparam int P = 40;
    localparam int W = 4;
    localparam int L = 200;
    localparam int E = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof_ok = 1'b0;
    logic en = 1'b0;
    logic susp = 1'b0;
    logic flag;
    logic active;

    int checks = 0;
    int errors = 0;

    bit s_sof [0:L];
    bit s_en  [0:L];
    bit s_sus [0:L];
    bit x_flg [0:L];
    bit x_act [0:L];
    bit g_flg [0:L];
    bit g_act [0:L];

    always #2.5 clk = ~clk;

    sof_marker_gen #(.FRAME_CYCLES(P), .WIN_CYCLES(W)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sof_ok_i       (sof_ok),
        .mark_en_i      (en),
        .suspend_i      (susp),
        .sof_flag_set_o (flag),
        .mark_active_o  (active)
    );

    task automatic clear_all();
        for (int n = 0; n <= L; n++) begin
            s_sof[n] = 0; s_en[n] = 0; s_sus[n] = 0;
            x_flg[n] = 0; x_act[n] = 0;
        end
    endtask

    task automatic check1(input string req, input bit got, input bit exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic run_case(input string req, input string name);
        int bad_f;
        int bad_a;
        rst_n = 1'b0; sof_ok = 0; en = 0; susp = 0;
        repeat (2) @(negedge clk);
        // R2: reset state
        check1("R2", flag, 1'b0, "flag in reset");
        check1("R2", active, 1'b0, "active in reset");
        rst_n = 1'b1;
        for (int n = 1; n <= L; n++) begin
            sof_ok = s_sof[n]; en = s_en[n]; susp = s_sus[n];
            @(negedge clk);
            g_flg[n] = flag; g_act[n] = active;
        end
        sof_ok = 0; en = 0; susp = 0;
        bad_f = -1; bad_a = -1;
        for (int n = 1; n <= L; n++) begin
            if (bad_f < 0 && g_flg[n] != x_flg[n]) bad_f = n;
            if (bad_a < 0 && g_act[n] != x_act[n]) bad_a = n;
        end
        checks += 2;
        if (bad_f >= 0) begin
            errors++;
            $display("FAIL %s %s flag at edge %0d: actual %0d expected %0d",
                     req, name, bad_f, g_flg[bad_f], x_flg[bad_f]);
        end
        if (bad_a >= 0) begin
            errors++;
            $display("FAIL %s %s active at edge %0d: actual %0d expected %0d",
                     req, name, bad_a, g_act[bad_a], x_act[bad_a]);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R5 R6 R7 R8: sweep second real SOF around the window
        for (int d = P - W - 3; d <= P + W + 3; d++) begin
            int a;
            int r2;
            bit used;
            clear_all();
            for (int n = 1; n <= L; n++) s_en[n] = 1;
            r2 = E + d;
            s_sof[E] = 1; s_sof[r2] = 1;
            x_flg[E] = 1; x_flg[r2] = 1;
            for (int n = E; n <= L; n++) x_act[n] = 1;
            a = E; used = 0;
            while (a + P + W <= L) begin
                if (!used && r2 > a && r2 <= a + P + W) begin
                    a = r2; used = 1;
                end else begin
                    x_flg[a + P + W] = 1;
                    a = a + P;
                end
            end
            run_case(d <= P + W ? "R7" : "R8", $sformatf("offset %0d", d));
        end

        // R3: enabled, no SOF ever
        clear_all();
        for (int n = 1; n <= L; n++) s_en[n] = 1;
        run_case("R3", "no sof");

        // R4 R5 R6: single SOF, then fill-in only
        clear_all();
        for (int n = 1; n <= L; n++) s_en[n] = 1;
        s_sof[E] = 1; x_flg[E] = 1;
        for (int n = E; n <= L; n++) x_act[n] = 1;
        for (int k = E + P + W; k <= L; k += P) x_flg[k] = 1;
        run_case("R6", "single sof");

        // R9 R1: enable dropped on the deadline edge, real SOF passes while off
        clear_all();
        for (int n = 1; n < E + P + W; n++) s_en[n] = 1;
        for (int n = 80; n <= L; n++) s_en[n] = 1;
        s_sof[E] = 1; s_sof[60] = 1;
        x_flg[E] = 1; x_flg[60] = 1;
        for (int n = E; n < E + P + W; n++) x_act[n] = 1;
        run_case("R9", "disable on deadline");

        // R10: suspend with enable held, then re-enable and fresh SOF
        clear_all();
        for (int n = 1; n <= L; n++) s_en[n] = 1;
        s_en[30] = 0;
        for (int n = 20; n <= 25; n++) s_sus[n] = 1;
        s_sof[E] = 1; s_sof[100] = 1;
        x_flg[E] = 1; x_flg[100] = 1;
        for (int k = 100 + P + W; k <= L; k += P) x_flg[k] = 1;
        for (int n = E; n < 20; n++) x_act[n] = 1;
        for (int n = 100; n <= L; n++) x_act[n] = 1;
        run_case("R10", "suspend");

        // R1: SOF during suspend still passes through
        clear_all();
        for (int n = 1; n <= L; n++) s_en[n] = 1;
        for (int n = 10; n <= 20; n++) s_sus[n] = 1;
        s_sof[15] = 1; x_flg[15] = 1;
        run_case("R1", "sof in suspend");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule